// File: doc/BRIEF.md
# Keypad Group Select Register

This block is a single memory-mapped register in front of an eight-button keypad. The buttons are arranged as two groups of four: direction keys on the lower half of the live button vector and action keys on the upper half. Software writes a two-bit group selector. Any read then returns the state of the chosen group in the low nibble, with a 0 for each pressed key and a 1 for each released key.

The selector can choose the direction group, the action group, both groups merged so that a key in either one reads as pressed, or no group at all. The block also watches whether any selected key is pressed. When that condition goes from false to true, it emits a one-cycle interrupt request pulse. A key that stays held does not raise a second request.

Top module: `kpd_select_reader`

## Requirements
- R1: After reset the selector is 2'b00 (both groups), so read bits 5:4 are 00, and the interrupt output is low.
- R2: A write latches write data bits 5:4 into the selector, and every later read returns those two bits unchanged in bits 5:4. The other written bits have no effect on the read data.
- R3: Read data bits 7:6 always read as 1.
- R4: With selector 2'b11 no group is chosen, so read bits 3:0 are 4'b1111 whatever the buttons are.
- R5: With selector 2'b10, read bits 3:0 equal the inverse of button bits 7:4 (the action group).
- R6: With selector 2'b01, read bits 3:0 equal the inverse of button bits 3:0 (the direction group).
- R7: With selector 2'b00, read bits 3:0 equal the inverse of (button bits 7:4 OR button bits 3:0).
- R8: The interrupt output is high for exactly one cycle, in the cycle after "any selected key pressed" first becomes true. While that condition stays true it does not pulse again.
- R9: A selector write that brings an already held key into the selected group counts as a rising edge of the pressed condition and raises the interrupt pulse.
- R10: Keys outside the selected group never raise the interrupt. With selector 2'b11 the interrupt stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| btn_i | input | 8 | Live buttons, 1 = pressed; [3:0] directions, [7:4] actions |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data; bits 5:4 are the group selector |
| rd_data_o | output | 8 | Register read data: 11, selector, inverted key nibble |
| irq_o | output | 1 | One-cycle keypad interrupt request |

## Verification
The assertions assume that the button vector is already synchronous to the clock and settles between clock edges. They also assume that the write strobe and write data are stable around each rising edge. The bench meets these assumptions by changing every input only on the falling edge and sampling outputs between edges. It sweeps all four selector values against all 256 button patterns, using write data whose non-selector bits are scrambled. It then runs the interrupt scenarios one at a time from a released-keypad state, so that each pulse can be tied to a single cause.

// File: rtl/kpd_pkg.sv
// Package: shared selector encoding for the keypad register.
// Assumes two button groups of equal width, low group = directions.
package kpd_pkg;
    typedef enum logic [1:0] {
        GRP_BOTH = 2'b00,
        GRP_LOW  = 2'b01,
        GRP_HIGH = 2'b10,
        GRP_NONE = 2'b11
    } grp_sel_e;
endpackage

// File: rtl/kpd_sel_reg.sv
// Holds the two-bit group selector written by software.
// Assumes the caller extracts the selector field from the write data.
module kpd_sel_reg
    import kpd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_en_i,
    input  logic [1:0] wr_sel_i,
    output grp_sel_e sel_o
);
    grp_sel_e sel_q;

    // Latch the selector on a write; reset chooses both groups.
    always_ff @(posedge clk) begin
        if (!rst_n)       sel_q <= GRP_BOTH;
        else if (wr_en_i) sel_q <= grp_sel_e'(wr_sel_i);
    end

    assign sel_o = sel_q;

    assert_sel_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> sel_q == grp_sel_e'($past(wr_sel_i)));
    assert_sel_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(sel_q));
endmodule

// File: rtl/kpd_group_mux.sv
// Builds the active-high "selected key pressed" nibble from the buttons.
// Assumes btn_i holds the low group in [G-1:0] and the high group above it.
module kpd_group_mux
    import kpd_pkg::*;
#(
    parameter int GROUP_W = 4
) (
    input  logic [2*GROUP_W-1:0] btn_i,
    input  grp_sel_e             sel_i,
    output logic [GROUP_W-1:0]   pressed_o,
    output logic                 any_o
);
    logic low_en;
    logic high_en;

    // A group is enabled when its selector bit is clear.
    always_comb begin
        low_en  = ~sel_i[1];
        high_en = ~sel_i[0];
    end

    for (genvar i = 0; i < GROUP_W; i++) begin : g_key
        assign pressed_o[i] = (btn_i[i] & low_en) | (btn_i[i+GROUP_W] & high_en);
    end

    assign any_o = |pressed_o;
endmodule

// File: rtl/kpd_irq_edge.sv
// Turns the level "any selected key pressed" into a one-cycle request.
// Assumes any_i is synchronous to clk.
module kpd_irq_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic any_i,
    output logic irq_o
);
    logic any_q;
    logic irq_q;

    // Remember the last level and pulse on its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            any_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            any_q <= any_i;
            irq_q <= any_i & ~any_q;
        end
    end

    assign irq_o = irq_q;

    assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q);
    assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> $past(any_i));
    assert_irq_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (any_i && any_q) |=> !irq_q);
endmodule

// File: rtl/kpd_select_reader.sv
// Keypad register: software picks a button group; reads return it inverted.
// Assumes btn_i is already debounced and synchronous; 1 = pressed.
module kpd_select_reader
    import kpd_pkg::*;
#(
    parameter int GROUP_W = 4,
    parameter int DATA_W  = 8,
    parameter int SEL_LSB = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2*GROUP_W-1:0] btn_i,
    input  logic                 wr_en_i,
    input  logic [DATA_W-1:0]    wr_data_i,
    output logic [DATA_W-1:0]    rd_data_o,
    output logic                 irq_o
);
    localparam int SEL_W = 2;

    grp_sel_e             sel;
    logic [GROUP_W-1:0]   pressed;
    logic                 any_pressed;

    kpd_sel_reg u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_en_i),
        .wr_sel_i (wr_data_i[SEL_LSB +: SEL_W]),
        .sel_o    (sel)
    );

    kpd_group_mux #(.GROUP_W(GROUP_W)) u_mux (
        .btn_i     (btn_i),
        .sel_i     (sel),
        .pressed_o (pressed),
        .any_o     (any_pressed)
    );

    kpd_irq_edge u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .any_i (any_pressed),
        .irq_o (irq_o)
    );

    // Compose read data: fixed ones, selector field, inverted key nibble.
    always_comb begin
        rd_data_o                        = '1;
        rd_data_o[SEL_LSB +: SEL_W]      = sel;
        rd_data_o[GROUP_W-1:0]           = ~pressed;
    end

    assert_fixed_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_o[DATA_W-1:DATA_W-2] == 2'b11);
    assert_none_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sel == GRP_NONE |-> rd_data_o[GROUP_W-1:0] == '1);
    assert_none_no_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sel == GRP_NONE |=> !irq_o);
endmodule

// File: tb/kpd_select_reader_bench.sv
module kpd_select_reader_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] btn_i = 8'h00;
    logic       wr_en_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic [7:0] rd_data_o;
    logic       irq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    kpd_select_reader u_kpd_select_reader (
        .clk(clk), .rst_n(rst_n), .btn_i(btn_i), .wr_en_i(wr_en_i),
        .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Write a selector at the next edge with scrambled other bits.
    task automatic wr_sel(input logic [1:0] s, input logic [7:0] junk);
        @(negedge clk);
        wr_data_i = (junk & 8'hCF) | {2'b00, s, 4'b0000};
        wr_en_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0;
        wr_data_i = ~wr_data_i;
    endtask

    function automatic logic [7:0] expect_rd(input logic [1:0] s, input logic [7:0] b);
        logic [3:0] n;
        case (s)
            2'b00: n = b[7:4] | b[3:0];
            2'b01: n = b[3:0];
            2'b10: n = b[7:4];
            default: n = 4'h0;
        endcase
        return {2'b11, s, ~n};
    endfunction

    // Quiet keypad, then let the edge detector settle.
    task automatic settle();
        @(negedge clk);
        btn_i = 8'h00;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        btn_i = 8'h00;
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 rd", rd_data_o, 8'hCF);
        check("R1 irq", {7'b0, irq_o}, 8'h00);

        // R2..R7: exhaustive selector x button sweep
        for (int s = 0; s < 4; s++) begin
            wr_sel(s[1:0], 8'hA5 ^ 8'(s * 37));
            for (int b = 0; b < 256; b++) begin
                btn_i = b[7:0];
                #1;
                case (s)
                    0: check("R7 both", rd_data_o, expect_rd(2'(s), b[7:0]));
                    1: check("R6 low", rd_data_o, expect_rd(2'(s), b[7:0]));
                    2: check("R5 high", rd_data_o, expect_rd(2'(s), b[7:0]));
                    default: check("R4 none", rd_data_o, expect_rd(2'(s), b[7:0]));
                endcase
                @(negedge clk);
            end
            check("R2 sel field", {6'b0, rd_data_o[5:4]}, 8'(s));
            check("R3 top ones", {6'b0, rd_data_o[7:6]}, 8'h03);
        end

        // R8: single pulse on press, no retrigger while held
        wr_sel(2'b01, 8'hFF);
        settle();
        btn_i = 8'h04;
        @(negedge clk);
        check("R8 pulse", {7'b0, irq_o}, 8'h01);
        @(negedge clk);
        check("R8 one cycle", {7'b0, irq_o}, 8'h00);
        btn_i = 8'h0C;
        repeat (3) @(negedge clk);
        check("R8 held no retrigger", {7'b0, irq_o}, 8'h00);
        btn_i = 8'h00;
        @(negedge clk);
        @(negedge clk);
        btn_i = 8'h01;
        @(negedge clk);
        check("R8 second press", {7'b0, irq_o}, 8'h01);

        // R10: unselected group key does not request
        settle();
        btn_i = 8'h10;
        repeat (2) @(negedge clk);
        check("R10 other group", {7'b0, irq_o}, 8'h00);

        // R9: selecting the group with the held key requests
        @(negedge clk);
        wr_data_i = 8'h20;
        wr_en_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0;
        check("R9 no irq yet", {7'b0, irq_o}, 8'h00);
        @(negedge clk);
        check("R9 irq after select", {7'b0, irq_o}, 8'h01);

        // R10: selector none with all keys held
        wr_sel(2'b11, 8'h00);
        settle();
        btn_i = 8'hFF;
        repeat (3) begin
            @(negedge clk);
            check("R10 none", {7'b0, irq_o}, 8'h00);
        end
        check("R4 none held", rd_data_o, 8'hFF);

        // R1: reset again returns selector to both groups
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        btn_i = 8'h00;
        #1;
        check("R1 reset again", rd_data_o, 8'hCF);
        finish_up();
    end
endmodule